// File: doc/BRIEF.md
# Debug Register Write Sequencer

This block is the write side of a debug port slave. A debug master drives it with a parallel byte stream. Each transaction opens with a start strobe that carries a register address. Any number of data bytes then follow, each marked by a valid strobe. Each data byte goes to the register at the current address.

For most targets the address then advances by one. A single burst can therefore walk through a bank of registers. The block holds five write-only instruction-store bytes. The store that holds the first opcode sits at the highest address of the bank. An incrementing burst that starts at the bottom of the bank therefore ends by writing that byte. That write raises a one-cycle execute strobe, with the assembled five-byte instruction presented beside it.

A separate memory-write data register does not advance the address. One address byte followed by a long run of data therefore streams into consecutive memory. Each byte leaves on a memory write port at the location given by a 24-bit program counter, and the counter then steps by one. In narrow mode the memory address is an 8-bit base input joined to the low 16 counter bits, and the counter steps only within those 16 bits. In wide mode the full 24-bit counter is the address. A load input sets the counter directly.

Top module: `dbg_wr_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `exec_o` and `mem_we_o` are 0.
- R2: The store bank spans addresses 21h to 25h. Address 21h holds store byte 4, 22h byte 3, 23h byte 2, 24h byte 1 and 25h byte 0. Byte 0 is the first opcode. `instr_o` carries store byte k at bits [8k+7:8k]. A store byte keeps its value until it is written again.
- R3: A data byte written to address 25h makes `exec_o` 1 for exactly the next cycle, with the updated `instr_o`. No other write raises `exec_o`.
- R4: After each data byte written to any address other than 30h, the register address increments by one, wrapping from FFh to 00h. This includes unmapped addresses.
- R5: A data byte written to address 30h makes `mem_we_o` 1 in the next cycle, with that byte on `mem_data_o` and the pre-write program counter address on `mem_addr_o`.
- R6: In narrow mode (`wide_mode_i`=0) the memory address is {`mem_base_i`, PC[15:0]}. In wide mode (`wide_mode_i`=1) it is PC[23:0].
- R7: Writes to address 30h leave the register address unchanged, so back-to-back data bytes go to consecutive memory locations, one per cycle.
- R8: After a memory write, narrow mode increments PC[15:0] modulo 2^16 and keeps PC[23:16]. Wide mode increments the whole 24-bit PC modulo 2^24.
- R9: `pc_load_i` sets the PC to `pc_load_val_i` at the next edge. When it coincides with a memory write, that write uses the old PC and the load wins over the increment.
- R10: A data byte written to an address outside 21h–25h that is not 30h changes no store byte and causes no execute or memory write.
- R11: When `start_i` and `valid_i` are high in the same cycle, the byte is taken only as the new address. No register or memory write occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start of transaction; `data_i` is the register address |
| valid_i | input | 1 | `data_i` is a data byte for the current address |
| data_i | input | 8 | Address or data byte from the master |
| wide_mode_i | input | 1 | 1 = wide 24-bit addressing, 0 = narrow base+16-bit |
| mem_base_i | input | 8 | Upper address byte used in narrow mode |
| pc_load_i | input | 1 | Load the program counter |
| pc_load_val_i | input | 24 | Value loaded into the program counter |
| exec_o | output | 1 | One-cycle execute strobe |
| instr_o | output | 40 | Five store bytes, byte 0 in the low bits |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | 24 | Memory write address |
| mem_data_o | output | 8 | Memory write data |

## Verification
Every result of this block is due exactly one clock edge after the data byte that causes it:
- The execute strobe and the instruction bus follow a write to address 25h by one edge.
- The memory write strobe, address and data follow a write to address 30h by one edge.
- A PC load is seen in the address of the next memory write.

The bench drives each input on a falling edge and samples the outputs on the following falling edge. Each sample therefore lands half a period after the edge that captured the byte. In memory streams the valid strobe stays high across bytes, and one check is made per cycle. The single-cycle execute pulse is confirmed by sampling again one cycle later.

// File: rtl/dbg_wr_pkg.sv
package dbg_wr_pkg;
    localparam int unsigned DATA_W    = 8;
    localparam int unsigned ADDR_W    = 8;
    localparam int unsigned PC_W      = 24;
    localparam int unsigned PC_LOW_W  = 16;
    localparam int unsigned NUM_STORE = 5;
    localparam logic [ADDR_W-1:0] STORE_BASE = 8'h21;
    localparam logic [ADDR_W-1:0] MEMWR_ADDR = 8'h30;
endpackage

// File: rtl/dbg_addr_ctl.sv
module dbg_addr_ctl #(
    parameter int unsigned        AW        = 8,
    parameter logic [AW-1:0]      HOLD_ADDR = 8'h30
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          valid_i,
    input  logic [AW-1:0] data_i,
    output logic [AW-1:0] addr_o,
    output logic          wr_o
);
    localparam logic [AW-1:0] ADDR_ONE = 1;

    typedef struct packed {
        logic [AW-1:0] addr;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.addr = data_i;
        end else if (valid_i && (st_q.addr != HOLD_ADDR)) begin
            st_d.addr = st_q.addr + ADDR_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign addr_o = st_q.addr;
    assign wr_o   = valid_i && !start_i;

    // R4
    addr_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !start_i && addr_o != HOLD_ADDR) |=> addr_o == $past(addr_o) + ADDR_ONE);
    // R7
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !start_i && addr_o == HOLD_ADDR) |=> $stable(addr_o));
    // R11
    addr_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> addr_o == $past(data_i));
endmodule

// File: rtl/dbg_istore.sv
module dbg_istore #(
    parameter int unsigned   DW   = 8,
    parameter int unsigned   AW   = 8,
    parameter int unsigned   NS   = 5,
    parameter logic [AW-1:0] BASE = 8'h21
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_i,
    input  logic [AW-1:0]  addr_i,
    input  logic [DW-1:0]  data_i,
    output logic           exec_o,
    output logic [NS*DW-1:0] instr_o
);
    typedef struct packed {
        logic                   exec;
        logic [NS-1:0][DW-1:0]  store;
    } st_t;

    st_t st_d, st_q;
    logic [NS-1:0] hit;

    // store byte i lives at BASE + (NS-1-i): byte 0 (first opcode) is highest
    for (genvar i = 0; i < NS; i++) begin : g_hit
        assign hit[i] = wr_i && (addr_i == AW'(BASE + AW'(NS - 1 - i)));
    end

    always_comb begin
        st_d      = st_q;
        st_d.exec = hit[0];
        for (int i = 0; i < NS; i++) begin
            if (hit[i]) st_d.store[i] = data_i;
        end
    end

    // store bytes carry no reset: their content is undefined until written
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.exec <= 1'b0;
        else        st_q      <= st_d;
    end

    assign exec_o  = st_q.exec;
    assign instr_o = st_q.store;

    // R3
    exec_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exec_o |=> !exec_o);
    // R3
    exec_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == AW'(BASE + AW'(NS - 1))) |=> exec_o);
    // R2
    store_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == BASE) |=> instr_o[NS*DW-1 -: DW] == $past(data_i));
endmodule

// File: rtl/dbg_memwr.sv
module dbg_memwr #(
    parameter int unsigned DW   = 8,
    parameter int unsigned PCW  = 24,
    parameter int unsigned LOWW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_i,
    input  logic [DW-1:0]        data_i,
    input  logic                 wide_i,
    input  logic [PCW-LOWW-1:0]  base_i,
    input  logic                 pc_load_i,
    input  logic [PCW-1:0]       pc_load_val_i,
    output logic                 mem_we_o,
    output logic [PCW-1:0]       mem_addr_o,
    output logic [DW-1:0]        mem_data_o
);
    localparam int unsigned HIW = PCW - LOWW;
    localparam logic [PCW-1:0]  PC_ONE  = 1;
    localparam logic [LOWW-1:0] LOW_ONE = 1;

    typedef struct packed {
        logic [PCW-1:0] pc;
        logic           we;
        logic [PCW-1:0] addr;
        logic [DW-1:0]  data;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.we = wr_i;
        if (wr_i) begin
            st_d.data = data_i;
            if (wide_i) begin
                st_d.addr = st_q.pc;
                st_d.pc   = st_q.pc + PC_ONE;
            end else begin
                st_d.addr = {base_i, st_q.pc[LOWW-1:0]};
                st_d.pc   = {st_q.pc[PCW-1 -: HIW], st_q.pc[LOWW-1:0] + LOW_ONE};
            end
        end
        if (pc_load_i) st_d.pc = pc_load_val_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mem_we_o   = st_q.we;
    assign mem_addr_o = st_q.addr;
    assign mem_data_o = st_q.data;

    // R5
    mem_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (mem_we_o && mem_data_o == $past(data_i)));
    // R8
    pc_wide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !pc_load_i && wide_i) |=> st_q.pc == $past(st_q.pc) + PC_ONE);
    // R8
    pc_narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !pc_load_i && !wide_i) |=>
            (st_q.pc[PCW-1 -: HIW] == $past(st_q.pc[PCW-1 -: HIW]) &&
             st_q.pc[LOWW-1:0] == $past(st_q.pc[LOWW-1:0]) + LOW_ONE));
    // R9
    pc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load_i |=> st_q.pc == $past(pc_load_val_i));
endmodule

// File: rtl/dbg_wr_seq.sv
module dbg_wr_seq
    import dbg_wr_pkg::*;
#(
    parameter int unsigned         DW        = DATA_W,
    parameter int unsigned         AW        = ADDR_W,
    parameter int unsigned         PCW       = PC_W,
    parameter int unsigned         LOWW      = PC_LOW_W,
    parameter int unsigned         NS        = NUM_STORE,
    parameter logic [AW-1:0]       ST_BASE   = STORE_BASE,
    parameter logic [AW-1:0]       MW_ADDR   = MEMWR_ADDR
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic                 valid_i,
    input  logic [DW-1:0]        data_i,
    input  logic                 wide_mode_i,
    input  logic [PCW-LOWW-1:0]  mem_base_i,
    input  logic                 pc_load_i,
    input  logic [PCW-1:0]       pc_load_val_i,
    output logic                 exec_o,
    output logic [NS*DW-1:0]     instr_o,
    output logic                 mem_we_o,
    output logic [PCW-1:0]       mem_addr_o,
    output logic [DW-1:0]        mem_data_o
);
    localparam logic [AW-1:0] ST_LAST = AW'(ST_BASE + AW'(NS - 1));

    logic [AW-1:0] addr_q;
    logic          wr;
    logic          mw_wr;
    logic          unmapped;

    dbg_addr_ctl #(.AW(AW), .HOLD_ADDR(MW_ADDR)) addr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .valid_i (valid_i),
        .data_i  (data_i[AW-1:0]),
        .addr_o  (addr_q),
        .wr_o    (wr)
    );

    dbg_istore #(.DW(DW), .AW(AW), .NS(NS), .BASE(ST_BASE)) store_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (wr),
        .addr_i  (addr_q),
        .data_i  (data_i),
        .exec_o  (exec_o),
        .instr_o (instr_o)
    );

    assign mw_wr = wr && (addr_q == MW_ADDR);

    dbg_memwr #(.DW(DW), .PCW(PCW), .LOWW(LOWW)) memwr_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_i          (mw_wr),
        .data_i        (data_i),
        .wide_i        (wide_mode_i),
        .base_i        (mem_base_i),
        .pc_load_i     (pc_load_i),
        .pc_load_val_i (pc_load_val_i),
        .mem_we_o      (mem_we_o),
        .mem_addr_o    (mem_addr_o),
        .mem_data_o    (mem_data_o)
    );

    assign unmapped = (addr_q < ST_BASE || addr_q > ST_LAST) && (addr_q != MW_ADDR);

    // R1
    rst_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!exec_o && !mem_we_o));
    // R10
    unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && unmapped) |=> (!exec_o && !mem_we_o && $stable(instr_o)));
    // R11
    start_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (!exec_o && !mem_we_o));
endmodule

// File: tb/dbg_wr_seq_tb_top.sv
`timescale 1ns/1ps
module dbg_wr_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        start_i, valid_i, wide_mode_i, pc_load_i;
    logic [7:0]  data_i, mem_base_i;
    logic [23:0] pc_load_val_i;
    logic        exec_o, mem_we_o;
    logic [39:0] instr_o;
    logic [23:0] mem_addr_o;
    logic [7:0]  mem_data_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    dbg_wr_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .valid_i(valid_i),
        .data_i(data_i), .wide_mode_i(wide_mode_i), .mem_base_i(mem_base_i),
        .pc_load_i(pc_load_i), .pc_load_val_i(pc_load_val_i),
        .exec_o(exec_o), .instr_o(instr_o), .mem_we_o(mem_we_o),
        .mem_addr_o(mem_addr_o), .mem_data_o(mem_data_o)
    );

    typedef struct packed {
        logic [7:0]  start;
        logic [3:0]  n;
        logic [39:0] stream;   // first byte sent in bits [39:32]
        logic [39:0] expect_instr;
    } vec_t;

    localparam vec_t VEC [5] = '{
        '{8'h21, 4'd5, 40'h11_22_33_44_55, 40'h11_22_33_44_55},
        '{8'h21, 4'd5, 40'hA0_B1_C2_D3_E4, 40'hA0_B1_C2_D3_E4},
        '{8'h23, 4'd3, 40'h77_88_99_00_00, 40'hA0_B1_77_88_99},
        '{8'h24, 4'd2, 40'h5A_C3_00_00_00, 40'hA0_B1_77_5A_C3},
        '{8'h25, 4'd1, 40'h0F_00_00_00_00, 40'hA0_B1_77_5A_0F}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_start(input logic [7:0] a);
        start_i = 1'b1; valid_i = 1'b0; data_i = a;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic do_byte(input logic [7:0] d);
        valid_i = 1'b1; data_i = d;
        @(negedge clk);
        valid_i = 1'b0;
    endtask

    task automatic load_pc(input logic [23:0] v);
        pc_load_i = 1'b1; pc_load_val_i = v;
        @(negedge clk);
        pc_load_i = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; start_i = 1'b0; valid_i = 1'b0; data_i = '0;
        wide_mode_i = 1'b1; mem_base_i = '0; pc_load_i = 1'b0; pc_load_val_i = '0;
        repeat (3) @(negedge clk);
        chk("R1 exec in reset", exec_o, 0);
        chk("R1 mem_we in reset", mem_we_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 exec after reset", exec_o, 0);
        chk("R1 mem_we after reset", mem_we_o, 0);

        // vector table: store bursts
        for (int v = 0; v < 5; v++) begin
            do_start(VEC[v].start);
            for (int k = 0; k < int'(VEC[v].n); k++) begin
                do_byte(VEC[v].stream[39-8*k -: 8]);
                if (k < int'(VEC[v].n) - 1) chk("R3 no early exec", exec_o, 0);
            end
            chk("R3 exec after byte0", exec_o, 1);
            chk("R2 R4 instr layout", instr_o, VEC[v].expect_instr);
            @(negedge clk);
            chk("R3 exec single pulse", exec_o, 0);
        end

        // unmapped addresses advance into memory-write register
        wide_mode_i = 1'b1;
        load_pc(24'h000100);
        do_start(8'h2E);
        do_byte(8'hAA); chk("R10 unmapped no write", {exec_o, mem_we_o}, 0);
        do_byte(8'hBB); chk("R10 unmapped no write", {exec_o, mem_we_o}, 0);
        do_byte(8'hCC);
        chk("R4 reached 30h", mem_we_o, 1);
        chk("R5 mem addr", mem_addr_o, 24'h000100);
        chk("R5 mem data", mem_data_o, 8'hCC);
        do_byte(8'hDD);
        chk("R7 still at 30h", {mem_we_o, mem_addr_o, mem_data_o}, {1'b1, 24'h000101, 8'hDD});
        @(negedge clk);
        chk("R5 we drops when idle", mem_we_o, 0);

        // stores unchanged by unmapped writes
        do_start(8'h25);
        do_byte(8'h42);
        chk("R10 stores kept", instr_o, 40'hA0_B1_77_5A_42);

        // address wrap FFh -> 00h, then climb to the store bank
        do_start(8'hFF);
        do_byte(8'hEE);
        for (int k = 0; k < 33; k++) begin
            do_byte(8'h80 + 8'(k));
            chk("R4 wrap region quiet", {exec_o, mem_we_o}, 0);
        end
        for (int k = 1; k <= 5; k++) do_byte(8'(k));
        chk("R4 wrap then exec", {exec_o, instr_o}, {1'b1, 40'h01_02_03_04_05});

        // wide stream crossing 16-bit boundary
        wide_mode_i = 1'b1;
        load_pc(24'h12FFFE);
        do_start(8'h30);
        for (int k = 0; k < 4; k++) begin
            do_byte(8'h10 + 8'(k));
            chk("R6 R8 wide addr", mem_addr_o, 24'h12FFFE + 24'(k));
            chk("R7 stream data", {mem_we_o, mem_data_o}, {1'b1, 8'h10 + 8'(k)});
        end

        // narrow stream wraps low 16 bits
        wide_mode_i = 1'b0;
        mem_base_i  = 8'hA5;
        load_pc(24'h34FFFE);
        for (int k = 0; k < 3; k++) begin
            do_byte(8'h60 + 8'(k));
            chk("R6 R8 narrow addr", mem_addr_o, {8'hA5, 16'hFFFE + 16'(k)});
        end
        wide_mode_i = 1'b1;
        do_byte(8'h70);
        chk("R8 narrow kept upper", mem_addr_o, 24'h340001);

        // full 24-bit wrap in wide mode
        load_pc(24'hFFFFFF);
        do_byte(8'h71); chk("R8 wide top", mem_addr_o, 24'hFFFFFF);
        do_byte(8'h72); chk("R8 wide wrap", mem_addr_o, 24'h000000);

        // load coinciding with a write
        pc_load_i = 1'b1; pc_load_val_i = 24'h555000;
        do_byte(8'h73);
        pc_load_i = 1'b0;
        chk("R9 write uses old pc", mem_addr_o, 24'h000001);
        do_byte(8'h74);
        chk("R9 load wins", mem_addr_o, 24'h555000);

        // start and valid together: address only
        @(negedge clk);
        start_i = 1'b1; valid_i = 1'b1; data_i = 8'h30;
        @(negedge clk);
        start_i = 1'b0; valid_i = 1'b0;
        chk("R11 no write on start", {exec_o, mem_we_o}, 0);
        do_byte(8'h99);
        chk("R11 then writes at 30h", {mem_we_o, mem_addr_o, mem_data_o},
            {1'b1, 24'h555001, 8'h99});

        finish_run();
    end
endmodule